// File: doc/BRIEF.md
# DMA Event Latch with Queue Tracking

The block sits at the front of a small transfer controller. It watches up to eight trigger lines, one per DMA channel, and records each trigger in a pending bit. It then offers one pending channel at a time to a downstream event queue. A channel is offered only while it is not already queued. When the queue takes a channel, that channel's queued bit is set. The channel then stays out of arbitration until software clears it or the transfer engine reports that the transfer is complete.

Software sees the block through a small register interface with one-cycle read latency. It can read the pending word and the queued word. It can withdraw events through a clear register: writing a one to a bit of that register drops both the pending and the queued bit of that channel. Triggers that arrive while a channel is already pending are absorbed, so each channel holds at most one outstanding event.

Top module: `dma_evt_tracker`

## Requirements
- R1: After reset, every pending bit and every queued bit is 0, `pushValid` is 0, and `busRdata` is 0.
- R2: A one-cycle pulse on `trigIn[n]` sets pending bit n at the next clock edge. A trigger on a channel that is already pending changes nothing.
- R3: `pushValid` is 1 exactly when some channel has pending=1 and queued=0. `pushChan` then gives the binary number of the lowest such channel.
- R4: In a cycle with `pushValid` and `pushReady` both 1, the queued bit of `pushChan` is set at the clock edge. A queued channel is never offered again, and new triggers on it are not forwarded.
- R5: A write to the clear register (address 0x1094) clears, at that edge, both the pending and the queued bit of every channel whose data bit is 1. Data bits that are 0 leave their channels unchanged.
- R6: A clear (by register write or by completion) and a trigger or queue accept on the same channel in the same cycle leave both of that channel's bits at 0.
- R7: A pulse on `doneIn[n]` clears pending bit n and queued bit n. A later trigger on channel n is latched and offered again.
- R8: A read with `busRe` returns data on `busRdata` one cycle later. Address 0x1080 returns the pending word and address 0x1090 returns the queued word, each in bits 7:0 with bits 31:8 at 0. The clear register and unmapped addresses read 0. In a cycle that follows no read, `busRdata` is 0.
- R9: Writes to the pending (0x1080) and queued (0x1090) addresses have no effect on any status bit.
- R10: While `pushReady` is 0 and no trigger, completion or clear arrives, `pushValid` stays 1 and `pushChan` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigIn | input | NUM_CH | Per-channel trigger pulses |
| doneIn | input | NUM_CH | Per-channel completion pulses from the transfer engine |
| pushValid | output | 1 | A channel is offered to the event queue |
| pushChan | output | $clog2(NUM_CH) | Number of the offered channel |
| pushReady | input | 1 | Event queue accepts the offered channel |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | DATA_W | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | DATA_W | Read data, one cycle after `busRe` |

## Verification
The bench builds the block with its default parameters: eight channels, a 16-bit address and a 32-bit data word. With these values it can sweep the priority order over every channel, from channel 0 through channel 7 with all eight pending at once. The data word is wider than the status field, so the bench can also confirm that the unused upper bits 31:8 read 0. The three register addresses are fixed at their defaults, so the read-only and write-one-clear checks run against the exact offsets named in the requirements.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PRI  = 2'd1,
    RD_SEC  = 2'd2
  } rdSel_e;

  // Strobes the control sends to the datapath each cycle.
  typedef struct packed {
    logic [7:0] clrMask;     // channels to clear (software or completion)
    logic [7:0] acceptMask;  // channel taken by the queue this cycle
    rdSel_e     rdSel;       // register captured into read data
  } evtStrobe_t;

endpackage

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 16'h1080,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'h1090,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h1094,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] priBits,
  input  logic [NUM_CH-1:0] secBits,
  input  logic [NUM_CH-1:0] doneIn,
  input  logic              pushReady,
  output logic              pushValid,
  output logic [CH_W-1:0]   pushChan,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output evtStrobe_t        strobe
);

  logic [NUM_CH-1:0] candMask;
  logic [NUM_CH-1:0] swClr;
  logic [NUM_CH-1:0] acceptMask;
  logic [CH_W-1:0]   pickIdx;

  assign candMask = priBits & ~secBits;

  // Fixed priority: the lowest-numbered candidate wins.
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (candMask[i]) pickIdx = CH_W'(i);
    end
  end

  assign pushValid = |candMask;
  assign pushChan  = pickIdx;

  always_comb begin
    acceptMask = '0;
    if (pushValid && pushReady) acceptMask[pickIdx] = 1'b1;
  end

  assign swClr = (busWe && busAddr == CLR_ADDR) ? busWdata[NUM_CH-1:0] : '0;

  always_comb begin
    strobe            = '0;
    strobe.clrMask    = swClr | doneIn;
    strobe.acceptMask = acceptMask;
    strobe.rdSel      = RD_NONE;
    if (busRe) begin
      if (busAddr == PRI_ADDR)      strobe.rdSel = RD_PRI;
      else if (busAddr == SEC_ADDR) strobe.rdSel = RD_SEC;
    end
  end

  // R4: an offered channel is pending and not yet queued
  assert_offer_unqueued_R4: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (priBits[pushChan] && !secBits[pushChan]));

  // R4: an accepted channel shows up as queued at the next edge
  assert_accept_marks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushReady && !strobe.clrMask[pushChan]) |=> secBits[$past(pushChan)]);

endmodule

// File: rtl/dma_evt_datapath.sv
module dma_evt_datapath
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] trigIn,
  input  evtStrobe_t        strobe,
  output logic [NUM_CH-1:0] priBits,
  output logic [NUM_CH-1:0] secBits,
  output logic [DATA_W-1:0] rdData
);

  logic [NUM_CH-1:0] clrMask;
  logic [NUM_CH-1:0] acceptMask;

  assign clrMask    = strobe.clrMask[NUM_CH-1:0];
  assign acceptMask = strobe.acceptMask[NUM_CH-1:0];

  // One status pair per channel; a clear overrides any set.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        priBits[g] <= 1'b0;
        secBits[g] <= 1'b0;
      end else if (clrMask[g]) begin
        priBits[g] <= 1'b0;
        secBits[g] <= 1'b0;
      end else begin
        if (trigIn[g])     priBits[g] <= 1'b1;
        if (acceptMask[g]) secBits[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      unique case (strobe.rdSel)
        RD_PRI:  rdData <= DATA_W'(priBits);
        RD_SEC:  rdData <= DATA_W'(secBits);
        default: rdData <= '0;
      endcase
    end
  end

  // R4: a channel can only be queued while it is pending
  assert_sec_needs_pri_R4: assert property (@(posedge clk) disable iff (!rstN)
    (secBits & ~priBits) == '0);

  // R6: cleared channels end with both bits low, whatever else arrived
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrMask != '0) |=> (((priBits | secBits) & $past(clrMask)) == '0));

  // R2: an uncleared trigger leaves its pending bit set
  assert_trig_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((trigIn & ~clrMask) != '0) |=> ((priBits & $past(trigIn & ~clrMask)) == $past(trigIn & ~clrMask)));

  // R8: no read in the previous cycle means zero read data
  assert_idle_rdata_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == RD_NONE) |=> (rdData == '0));

endmodule

// File: rtl/dma_evt_tracker.sv
module dma_evt_tracker
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] PRI_ADDR = 16'h1080,
  parameter logic [ADDR_W-1:0] SEC_ADDR = 16'h1090,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 16'h1094,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] trigIn,
  input  logic [NUM_CH-1:0] doneIn,
  output logic              pushValid,
  output logic [CH_W-1:0]   pushChan,
  input  logic              pushReady,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata
);

  logic [NUM_CH-1:0] priBits;
  logic [NUM_CH-1:0] secBits;
  evtStrobe_t        strobe;

  dma_evt_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PRI_ADDR(PRI_ADDR), .SEC_ADDR(SEC_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .priBits(priBits), .secBits(secBits),
    .doneIn(doneIn), .pushReady(pushReady), .pushValid(pushValid),
    .pushChan(pushChan), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRe(busRe), .strobe(strobe)
  );

  dma_evt_datapath #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .strobe(strobe),
    .priBits(priBits), .secBits(secBits), .rdData(busRdata)
  );

  // R10: with nothing arriving, a stalled offer holds
  assert_offer_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushReady && trigIn == '0 && doneIn == '0 &&
     !(busWe && busAddr == CLR_ADDR)) |=> (pushValid && $stable(pushChan)));

endmodule

// File: tb/dma_evt_tracker_test.sv
module dma_evt_tracker_test;

  localparam logic [15:0] A_PRI = 16'h1080;
  localparam logic [15:0] A_SEC = 16'h1090;
  localparam logic [15:0] A_CLR = 16'h1094;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  trigIn = '0;
  logic [7:0]  doneIn = '0;
  logic        pushValid;
  logic [2:0]  pushChan;
  logic        pushReady = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_evt_tracker uut (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .doneIn(doneIn),
    .pushValid(pushValid), .pushChan(pushChan), .pushReady(pushReady),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRe(busRe), .busRdata(busRdata)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRe = 1'b1;
    @(negedge clk); busRe = 1'b0; d = busRdata;
  endtask

  task automatic writeReg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0; busWdata = '0;
  endtask

  task automatic pulseTrig(input logic [7:0] m);
    @(negedge clk); trigIn = m;
    @(negedge clk); trigIn = '0;
  endtask

  task automatic pulseDone(input logic [7:0] m);
    @(negedge clk); doneIn = m;
    @(negedge clk); doneIn = '0;
  endtask

  task automatic acceptOne();
    @(negedge clk); pushReady = 1'b1;
    @(negedge clk); pushReady = 1'b0;
  endtask

  task automatic expectRegs(input string req, input logic [7:0] p, input logic [7:0] s);
    logic [31:0] d;
    readReg(A_PRI, d); check(req, "pending word", d, {24'h0, p});
    readReg(A_SEC, d); check(req, "queued word", d, {24'h0, s});
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "pushValid", {31'h0, pushValid}, 32'h0);
    check("R1", "rdata", busRdata, 32'h0);
    expectRegs("R1", 8'h00, 8'h00);
  endtask

  task automatic testTrigger();
    pulseTrig(8'h24);
    check("R3", "pushValid", {31'h0, pushValid}, 32'h1);
    check("R3", "pushChan low wins", {29'h0, pushChan}, 32'd2);
    expectRegs("R2", 8'h24, 8'h00);
  endtask

  task automatic testAccept();
    acceptOne();
    check("R4", "next channel offered", {29'h0, pushChan}, 32'd5);
    expectRegs("R4", 8'h24, 8'h04);
    pulseTrig(8'h04);
    check("R4", "queued channel not re-offered", {29'h0, pushChan}, 32'd5);
    expectRegs("R2", 8'h24, 8'h04);
  endtask

  task automatic testStall();
    repeat (4) @(negedge clk);
    check("R10", "pushValid held", {31'h0, pushValid}, 32'h1);
    check("R10", "pushChan held", {29'h0, pushChan}, 32'd5);
    acceptOne();
    check("R4", "nothing left to offer", {31'h0, pushValid}, 32'h0);
    expectRegs("R4", 8'h24, 8'h24);
  endtask

  task automatic testClear();
    logic [31:0] d;
    writeReg(A_CLR, 32'h0);
    expectRegs("R5", 8'h24, 8'h24);
    writeReg(A_CLR, 32'h04);
    expectRegs("R5", 8'h20, 8'h20);
    readReg(A_CLR, d); check("R8", "clear reg reads zero", d, 32'h0);
  endtask

  task automatic testReadOnly();
    logic [31:0] d;
    writeReg(A_PRI, 32'hFFFF_FFFF);
    writeReg(A_SEC, 32'hFFFF_FFFF);
    writeReg(A_PRI, 32'h0);
    writeReg(A_SEC, 32'h0);
    expectRegs("R9", 8'h20, 8'h20);
    readReg(16'h1000, d); check("R8", "unmapped reads zero", d, 32'h0);
  endtask

  task automatic testDone();
    pulseDone(8'h20);
    check("R7", "pushValid after done", {31'h0, pushValid}, 32'h0);
    expectRegs("R7", 8'h00, 8'h00);
    pulseTrig(8'h20);
    check("R7", "retrigger offered", {31'h0, pushValid}, 32'h1);
    check("R7", "retrigger channel", {29'h0, pushChan}, 32'd5);
  endtask

  task automatic testClearWins();
    @(negedge clk);
    trigIn = 8'h08; busAddr = A_CLR; busWdata = 32'h08; busWe = 1'b1;
    @(negedge clk);
    trigIn = '0; busWe = 1'b0; busWdata = '0;
    expectRegs("R6", 8'h20, 8'h00);
    @(negedge clk);
    pushReady = 1'b1; busAddr = A_CLR; busWdata = 32'h20; busWe = 1'b1;
    @(negedge clk);
    pushReady = 1'b0; busWe = 1'b0; busWdata = '0;
    check("R6", "pushValid after clear vs accept", {31'h0, pushValid}, 32'h0);
    expectRegs("R6", 8'h00, 8'h00);
  endtask

  task automatic testLatency();
    pulseTrig(8'h01);
    @(negedge clk); busAddr = A_PRI; busRe = 1'b1;
    check("R8", "no data before edge", busRdata, 32'h0);
    @(negedge clk); busRe = 1'b0;
    check("R8", "data one cycle later", busRdata, 32'h1);
    @(negedge clk);
    check("R8", "idle rdata zero", busRdata, 32'h0);
    pulseDone(8'h01);
  endtask

  task automatic testPriority();
    pulseTrig(8'hFF);
    for (int i = 0; i < 8; i++) begin
      check("R3", "sweep valid", {31'h0, pushValid}, 32'h1);
      check("R3", "sweep order", {29'h0, pushChan}, i);
      acceptOne();
    end
    check("R4", "all queued", {31'h0, pushValid}, 32'h0);
    expectRegs("R4", 8'hFF, 8'hFF);
    pulseDone(8'hFF);
    expectRegs("R7", 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testTrigger();
    testAccept();
    testStall();
    testClear();
    testReadOnly();
    testDone();
    testClearWins();
    testLatency();
    testPriority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule